// File: doc/BRIEF.md
# Streaming Decimal Number Recognizer

This block checks, one character at a time, whether a stream of ASCII bytes forms a well-formed decimal real number. Each byte arrives with a strobe. A synchronous clear marks the start of a new candidate string. After each accepted byte the indicator output shows whether the characters received since the last clear make a complete number. The output is meant to drive a status LED directly.

A number may begin with one minus sign. At least one digit must follow. After that, a point may appear, and if it does, one or more digits must follow it. Any other character, or any character in the wrong place, sends the machine into a rejecting state. It stays there until the next clear or reset. The machine has six states, and the indicator is a function of the state alone, so it changes on the clock edge that consumes a byte.

Top module: `dec_num_recognizer`

## Requirements
- R1: After reset the indicator is low, and the empty string is never reported as a number.
- R2: A byte is a digit when its value is in the range 0x30 to 0x39 inclusive. The minus sign is 0x2D and the point is 0x2E. The bytes 0x2F and 0x3A are not digits.
- R3: A string of one or more digits, with or without a single leading minus sign, drives the indicator high from the edge that consumes its first digit.
- R4: A point after the integer digits drops the indicator until at least one fractional digit has been consumed. A string that ends in a point is reported low.
- R5: A lone minus sign reports low. A minus sign anywhere other than the first position rejects the string.
- R6: Any byte that has no legal transition from the current position moves the machine to a reject state. A second point and a leading point are examples. That state keeps the indicator low whatever bytes follow, until a clear.
- R7: On a cycle where the strobe is low, the byte input is ignored and the state is held.
- R8: The clear returns the machine to its start state with the indicator low. It takes priority over a strobe in the same cycle, and the byte offered in that cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous restart of recognition |
| chr_valid | input | 1 | Strobe: the byte on `chr` is consumed this cycle |
| chr | input | 8 | ASCII character |
| number_ok | output | 1 | High when the input since the last clear is a complete valid number |

## Verification
The clear and a byte strobe can arrive in the same cycle. In that case the clear must win and the offered byte must leave no trace. The bench provokes this in two ways. It raises both inputs together while the machine sits in an accepting state and while it sits in the reject state. It offers a digit in both cases. It then judges the outcome from the indicator, which must be low on the next cycle. It also checks that a string built afterwards is evaluated as though that digit had never been sent. A behavioural string parser in the bench computes the expected indicator, and the bench compares it with the output on every cycle.

// File: rtl/dec_num_recognizer.sv
module dec_num_recognizer #(
  parameter int CH_W      = 8,
  parameter logic [CH_W-1:0] MINUS_CODE = 8'h2D,
  parameter logic [CH_W-1:0] POINT_CODE = 8'h2E,
  parameter logic [CH_W-1:0] DIGIT_LO   = 8'h30,
  parameter logic [CH_W-1:0] DIGIT_HI   = 8'h39
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            chr_valid,
  input  logic [CH_W-1:0] chr,
  output logic            number_ok
);

  typedef enum logic [2:0] {
    S_START, S_SIGN, S_INT, S_POINT, S_FRAC, S_REJ
  } state_t;

  state_t state, nxt;

  logic is_dig, is_minus, is_point;
  assign is_dig   = (chr >= DIGIT_LO) && (chr <= DIGIT_HI);
  assign is_minus = (chr == MINUS_CODE);
  assign is_point = (chr == POINT_CODE);

  always_comb begin
    nxt = state;
    if (chr_valid) begin
      unique case (state)
        S_START: nxt = is_dig ? S_INT : (is_minus ? S_SIGN : S_REJ);
        S_SIGN:  nxt = is_dig ? S_INT : S_REJ;
        S_INT:   nxt = is_dig ? S_INT : (is_point ? S_POINT : S_REJ);
        S_POINT: nxt = is_dig ? S_FRAC : S_REJ;
        S_FRAC:  nxt = is_dig ? S_FRAC : S_REJ;
        default: nxt = S_REJ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     state <= S_START;
    else if (clear) state <= S_START;
    else            state <= nxt;

  assign number_ok = (state == S_INT) || (state == S_FRAC);

  a_r8_clear_to_start: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (state == S_START) && !number_ok);

  a_r7_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !chr_valid) |=> $stable(state));

  a_r6_reject_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_REJ && !clear) |=> (state == S_REJ));

  a_r3_rise_needs_digit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(number_ok) |-> ($past(chr_valid) && $past(chr) >= DIGIT_LO && $past(chr) <= DIGIT_HI));

  a_r5_lone_minus_low: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_START && chr_valid && !clear && chr == MINUS_CODE) |=> !number_ok);

  a_r4_point_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (number_ok && chr_valid && !clear && chr == POINT_CODE) |=> !number_ok);

endmodule

// File: tb/dec_num_recognizer_test.sv
module dec_num_recognizer_test;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear = 1'b0;
  logic chr_valid = 1'b0;
  logic [7:0] chr = 8'h00;
  logic number_ok;

  int checks = 0;
  int fails = 0;
  logic [7:0] q[$];

  always #(PERIOD/2) clk = ~clk;

  dec_num_recognizer uut (
    .clk(clk), .rst_n(rst_n), .clear(clear),
    .chr_valid(chr_valid), .chr(chr), .number_ok(number_ok)
  );

  function automatic bit is_digit(logic [7:0] c);
    return (c >= 8'd48) && (c <= 8'd57);
  endfunction

  function automatic bit model_ok();
    int i;
    int n;
    int d;
    i = 0;
    n = q.size();
    if (i < n && q[i] == 8'd45) i++;
    d = 0;
    while (i < n && is_digit(q[i])) begin i++; d++; end
    if (d == 0) return 1'b0;
    if (i == n) return 1'b1;
    if (q[i] != 8'd46) return 1'b0;
    i++;
    d = 0;
    while (i < n && is_digit(q[i])) begin i++; d++; end
    return (d > 0) && (i == n);
  endfunction

  task automatic check(string tag);
    bit exp;
    exp = model_ok();
    checks++;
    if (number_ok !== exp) begin
      fails++;
      $display("FAIL %s: number_ok=%b expected %b", tag, number_ok, exp);
    end
  endtask

  task automatic step(bit clr, bit v, logic [7:0] c, string tag);
    clear = clr;
    chr_valid = v;
    chr = c;
    if (clr) q.delete();
    else if (v) q.push_back(c);
    @(negedge clk);
    check(tag);
  endtask

  task automatic feed(string s, string tag);
    for (int k = 0; k < s.len(); k++) step(1'b0, 1'b1, s[k], tag);
  endtask

  task automatic restart(string tag);
    step(1'b1, 1'b0, 8'h00, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset");
    step(1'b0, 1'b0, 8'h35, "R1 idle");

    feed("123", "R3 digits");
    restart("R8");
    feed("-45", "R3 signed");
    restart("R8");
    feed("-", "R5 lone minus");
    feed("7", "R5 minus then digit");
    restart("R8");
    feed("3.14", "R4 fraction");
    restart("R8");
    feed("7.", "R4 trailing point");
    restart("R8");
    feed("--1", "R5 double minus");
    restart("R8");
    feed("1-2", "R5 inner minus");
    restart("R8");
    feed("1.2.3", "R6 second point");
    restart("R8");
    feed(".5", "R6 leading point");
    restart("R8");
    feed("1a55.5", "R6 sticky reject");
    restart("R8");
    feed("0", "R2 low bound");
    feed("9", "R2 high bound");
    feed("/", "R2 below range");
    restart("R8");
    feed(":", "R2 above range");
    restart("R8");
    feed("5", "R7");
    step(1'b0, 1'b0, 8'h41, "R7 ignored byte");
    step(1'b0, 1'b0, 8'h2E, "R7 ignored point");
    feed(".", "R7 then point");
    step(1'b0, 1'b0, 8'h78, "R7 ignored");
    feed("2", "R7 then digit");
    step(1'b1, 1'b1, 8'h33, "R8 clear wins over digit");
    feed(".", "R8 discarded digit");
    restart("R8");
    feed("x", "R6");
    step(1'b1, 1'b1, 8'h34, "R8 clear from reject");
    step(1'b0, 1'b0, 8'h00, "R8 empty string");
    feed("-0.0", "R8 fresh string");
    restart("R8");
    step(1'b0, 1'b0, 8'h00, "R1 empty after clear");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule